// File: doc/BRIEF.md
# Programmable Asynchronous Character Transmitter

This block serializes one parallel character at a time onto an asynchronous serial line. Two small stored bytes govern it. A format byte selects the number of data bits, the parity option, the stop length and the bit period. A control byte holds the transmit enable and a line-break request. All three bytes arrive on one shared write-data bus, each with its own write strobe.

A one-character holding register sits in front of the shift register, so the next character can be written while the current one is still going out. The bit timing is driven by a one-cycle tick enable. The tick marks each falling edge of the transmit clock. A clear-to-send input, active low, must be asserted before a new frame may start. Two flags serve flow control: a ready flag says the holding register can take a character, and an empty flag says nothing is queued or on the wire.

Top module: `async_char_tx`

## Requirements
- R1: After reset, `txd_o` is 1, `tx_ready_o` is 0 and `tx_empty_o` is 1. While no frame is in progress, the line rests at 1 (mark).
- R2: Each frame is sent in this order: one start bit at 0, the data bits least significant first, an optional parity bit, and then stop time at 1.
- R3: Format bits [3:2] set the number of data bits. The values 00, 01, 10 and 11 give 5, 6, 7 and 8 bits. Character bits above that length are not sent.
- R4: Format bit 4 set to 1 adds a parity bit. Format bit 5 picks its sense: 0 makes the total count of ones in data plus parity odd, and 1 makes it even.
- R5: Format bits [7:6] set the stop time. 01 gives one bit period, 11 gives two, and 10 gives one and a half, which is (3·F+1)/2 ticks for a bit period of F ticks. The value 00 acts as 01.
- R6: Format bits [1:0] set the bit period F in ticks. 01 gives 1, 10 gives 16 and 11 gives 64. The value 00 acts as 01.
- R7: `tx_ready_o` is 1 exactly when control bit 0 (transmit enable) is 1, `cts_ni` is 0 and the holding register is empty. It falls in the cycle after a character write.
- R8: `tx_empty_o` is 1 exactly when the holding register is empty and no frame is in progress. It falls in the cycle after a character write.
- R9: A held character enters the shift register only at the tick that ends the last stop tick of the current frame, or at a tick while the line is idle. Back-to-back frames leave no idle ticks between them. A character write while the holding register is full is ignored.
- R10: A new frame starts only when transmit enable is 1 and `cts_ni` is 0. A frame already in progress runs to the end of its stop time even if either condition is withdrawn.
- R11: While control bit 3 (line break) is 1, `txd_o` is 0. When it clears, the line returns to its normal value.
- R12: `txd_o` changes only in the cycle after a tick, unless the break bit changes. The format in force is captured when a frame starts, so a format write during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdata_i | input | 8 | Shared write data for format, control and character |
| fmt_we_i | input | 1 | Writes the format byte |
| ctl_we_i | input | 1 | Writes the control byte (bit 0 enable, bit 3 break) |
| char_we_i | input | 1 | Writes a character into the holding register |
| tick_i | input | 1 | One-cycle enable marking a transmit-clock falling edge |
| cts_ni | input | 1 | Clear to send, active low |
| txd_o | output | 1 | Serial data line |
| tx_ready_o | output | 1 | Holding register can take a character |
| tx_empty_o | output | 1 | Nothing queued and nothing being sent |

## Verification
The assertions check the per-cycle invariants on every cycle:
- the line stays at mark while idle;
- the line moves only after a tick;
- no frame launches without permission;
- the tick counter stays within its limit;
- the holding register is handed over only while full and stays unchanged until then.

The bench scenarios cover the behaviour that needs a whole frame to show. They compare the captured bit stream against an independently built frame for several length, parity, stop and rate combinations. They also cover seamless back-to-back frames, a frame finishing after clear-to-send is withdrawn, the break override, and a format byte written during a frame.

// File: rtl/tx_pkg.sv
package tx_pkg;

    localparam int CNT_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] stop;
        logic       par_even;
        logic       par_en;
        logic [1:0] len;
        logic [1:0] rate;
    } frame_cfg_t;

    // Ticks per bit; unsupported code 00 runs at one tick per bit
    function automatic logic [CNT_W-1:0] bit_ticks(input logic [1:0] rate);
        case (rate)
            2'b10:   bit_ticks = CNT_W'(16);
            2'b11:   bit_ticks = CNT_W'(64);
            default: bit_ticks = CNT_W'(1);
        endcase
    endfunction

    // Ticks of stop time; 1.5 bits rounds up, invalid 00 acts as one bit
    function automatic logic [CNT_W-1:0] stop_ticks(input logic [1:0] rate,
                                                    input logic [1:0] stop);
        logic [CNT_W:0] f;
        logic [CNT_W:0] t;
        f = {1'b0, bit_ticks(rate)};
        case (stop)
            2'b10:   t = (3 * f + 1) >> 1;
            2'b11:   t = f << 1;
            default: t = f;
        endcase
        stop_ticks = t[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/tx_ctrl_regs.sv
module tx_ctrl_regs (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [7:0] wdata_i,
    input  logic       fmt_we_i,
    input  logic       ctl_we_i,
    output logic [7:0] fmt_o,
    output logic       tx_en_o,
    output logic       brk_o
);

    typedef struct packed {
        logic [7:0] fmt;
        logic       tx_en;
        logic       brk;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (fmt_we_i) begin
            regs_d.fmt = wdata_i;
        end
        if (ctl_we_i) begin
            regs_d.tx_en = wdata_i[0];
            regs_d.brk   = wdata_i[3];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    assign fmt_o   = regs_q.fmt;
    assign tx_en_o = regs_q.tx_en;
    assign brk_o   = regs_q.brk;

endmodule

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              take_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take_i) begin
            hold_d.full = 1'b0;
        end else if (load_i && !hold_q.full) begin
            hold_d.full = 1'b1;
            hold_d.data = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hold_q <= '0;
        else         hold_q <= hold_d;
    end

    assign full_o = hold_q.full;
    assign data_o = hold_q.data;

    AST_TAKE_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_i |-> hold_q.full); // R9

    AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_q.full && !take_i) |=> (hold_q.full && $stable(hold_q.data))); // R9

endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
    import tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              start_en_i,
    input  logic              hold_full_i,
    input  logic [DATA_W-1:0] hold_data_i,
    input  logic [7:0]        fmt_i,
    output logic              take_o,
    output logic              busy_o,
    output logic              line_o
);

    localparam int IDX_W = $clog2(DATA_W);

    typedef struct packed {
        tx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shf;
        logic              par;
        frame_cfg_t        cfg;
        logic              line;
    } ser_t;

    ser_t ser_d, ser_q;

    logic [CNT_W-1:0]  lim;
    logic              bit_end;
    logic              launch;
    logic [IDX_W-1:0]  last_idx;
    frame_cfg_t        new_cfg;
    logic [DATA_W-1:0] new_mask;

    always_comb begin
        new_cfg  = frame_cfg_t'(fmt_i);
        new_mask = {DATA_W{1'b1}} >> (2'd3 - new_cfg.len);
        lim      = (ser_q.st == S_STOP) ? stop_ticks(ser_q.cfg.rate, ser_q.cfg.stop)
                                        : bit_ticks(ser_q.cfg.rate);
        bit_end  = (ser_q.cnt == lim - CNT_W'(1));
        last_idx = IDX_W'(4) + IDX_W'(ser_q.cfg.len);
        launch   = tick_i && start_en_i && hold_full_i &&
                   ((ser_q.st == S_IDLE) || ((ser_q.st == S_STOP) && bit_end));

        ser_d = ser_q;
        if (tick_i && ser_q.st != S_IDLE) begin
            if (!bit_end) begin
                ser_d.cnt = ser_q.cnt + CNT_W'(1);
            end else begin
                ser_d.cnt = '0;
                case (ser_q.st)
                    S_START: begin
                        ser_d.st   = S_DATA;
                        ser_d.idx  = '0;
                        ser_d.line = ser_q.shf[0];
                    end
                    S_DATA: begin
                        if (ser_q.idx == last_idx) begin
                            ser_d.st   = ser_q.cfg.par_en ? S_PAR : S_STOP;
                            ser_d.line = ser_q.cfg.par_en ? ser_q.par : 1'b1;
                        end else begin
                            ser_d.idx  = ser_q.idx + IDX_W'(1);
                            ser_d.shf  = ser_q.shf >> 1;
                            ser_d.line = ser_q.shf[1];
                        end
                    end
                    S_PAR: begin
                        ser_d.st   = S_STOP;
                        ser_d.line = 1'b1;
                    end
                    default: begin
                        ser_d.st   = S_IDLE;
                        ser_d.line = 1'b1;
                    end
                endcase
            end
        end

        if (launch) begin
            ser_d.st   = S_START;
            ser_d.cnt  = '0;
            ser_d.idx  = '0;
            ser_d.cfg  = new_cfg;
            ser_d.shf  = hold_data_i;
            ser_d.par  = new_cfg.par_even ? (^(hold_data_i & new_mask))
                                          : ~(^(hold_data_i & new_mask));
            ser_d.line = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ser_q      <= '0;
            ser_q.st   <= S_IDLE;
            ser_q.line <= 1'b1;
        end else begin
            ser_q <= ser_d;
        end
    end

    assign take_o = launch;
    assign busy_o = (ser_q.st != S_IDLE);
    assign line_o = ser_q.line;

    AST_IDLE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ser_q.st == S_IDLE) |-> line_o); // R1

    AST_QUIET_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(line_o)); // R12

    AST_GATED_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((ser_q.st == S_IDLE) && !start_en_i) |=> (ser_q.st == S_IDLE)); // R10

    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ser_q.st != S_IDLE) |-> (ser_q.cnt < lim)); // R6

endmodule

// File: rtl/async_char_tx.sv
module async_char_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              fmt_we_i,
    input  logic              ctl_we_i,
    input  logic              char_we_i,
    input  logic              tick_i,
    input  logic              cts_ni,
    output logic              txd_o,
    output logic              tx_ready_o,
    output logic              tx_empty_o
);

    logic [7:0]        fmt;
    logic              tx_en;
    logic              brk;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              busy;
    logic              line;
    logic              start_en;

    tx_ctrl_regs u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wdata_i  (wdata_i[7:0]),
        .fmt_we_i (fmt_we_i),
        .ctl_we_i (ctl_we_i),
        .fmt_o    (fmt),
        .tx_en_o  (tx_en),
        .brk_o    (brk)
    );

    tx_hold_buf #(.DATA_W(DATA_W)) u_hold (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (char_we_i),
        .wdata_i (wdata_i),
        .take_i  (take),
        .full_o  (hold_full),
        .data_o  (hold_data)
    );

    assign start_en = tx_en && !cts_ni;

    tx_serializer #(.DATA_W(DATA_W)) u_ser (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick_i),
        .start_en_i  (start_en),
        .hold_full_i (hold_full),
        .hold_data_i (hold_data),
        .fmt_i       (fmt),
        .take_o      (take),
        .busy_o      (busy),
        .line_o      (line)
    );

    assign tx_ready_o = start_en && !hold_full;
    assign tx_empty_o = !hold_full && !busy;
    assign txd_o      = line && !brk;

endmodule

// File: tb/async_char_tx_tb_top.sv
module async_char_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    typedef struct packed {
        logic [7:0] fmt;
        logic [7:0] data;
    } vec_t;

    // fmt: [7:6] stop, [5] even, [4] parity on, [3:2] length, [1:0] rate
    localparam vec_t VECS [NVEC] = '{
        '{8'h4D, 8'hA5},  // 8 bits, no parity, 1 stop, x1
        '{8'hF1, 8'h3B},  // 5 bits, even, 2 stop, x1
        '{8'h9A, 8'h5C},  // 7 bits, odd, 1.5 stop, x16
        '{8'h77, 8'hC9},  // 6 bits, even, 1 stop, x64
        '{8'h8D, 8'h81},  // 8 bits, no parity, 1.5 stop, x1
        '{8'hDE, 8'hFF}   // 8 bits, odd, 2 stop, x16
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] wdata = '0;
    logic       fmt_we = 1'b0;
    logic       ctl_we = 1'b0;
    logic       char_we = 1'b0;
    logic       tick = 1'b0;
    logic       cts_n = 1'b0;
    logic       txd, ready, empty;

    int n_tests = 0;
    int n_fail = 0;
    int stable_bad = 0;
    int ncap = 0;
    int nexp = 0;
    bit done = 1'b0;
    logic cap [0:2047];
    logic expb [0:2047];

    always #(CLK_PERIOD/2) clk = ~clk;

    async_char_tx dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .wdata_i    (wdata),
        .fmt_we_i   (fmt_we),
        .ctl_we_i   (ctl_we),
        .char_we_i  (char_we),
        .tick_i     (tick),
        .cts_ni     (cts_n),
        .txd_o      (txd),
        .tx_ready_o (ready),
        .tx_empty_o (empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v, input int which);
        @(negedge clk);
        wdata = v;
        fmt_we = (which == 0);
        ctl_we = (which == 1);
        char_we = (which == 2);
        @(negedge clk);
        fmt_we = 1'b0;
        ctl_we = 1'b0;
        char_we = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        logic prev;
        prev = txd;
        for (int i = 0; i < n; i++) begin
            if (txd !== prev) stable_bad++;
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            cap[ncap] = txd;
            prev = txd;
            ncap++;
            @(negedge clk);
        end
    endtask

    function automatic int rate_f(input logic [1:0] r);
        return (r == 2'b10) ? 16 : (r == 2'b11) ? 64 : 1;
    endfunction

    task automatic push(input logic b, input int n);
        for (int i = 0; i < n; i++) begin
            expb[nexp] = b;
            nexp++;
        end
    endtask

    task automatic add_frame(input logic [7:0] m, input logic [7:0] d);
        int f, nb, ones, st;
        f = rate_f(m[1:0]);
        nb = 5 + int'(m[3:2]);
        ones = 0;
        push(1'b0, f);
        for (int i = 0; i < nb; i++) begin
            push(d[i], f);
            ones += int'(d[i]);
        end
        if (m[4]) push(m[5] ? ones[0] : ~ones[0], f);
        st = (m[7:6] == 2'b10) ? (3 * f + 1) / 2 : (m[7:6] == 2'b11) ? 2 * f : f;
        push(1'b1, st);
    endtask

    task automatic cmp_stream(input int n, input string req);
        int bad;
        bad = -1;
        for (int i = 0; i < n; i++) begin
            if (cap[i] !== expb[i] && bad < 0) bad = i;
        end
        if (bad < 0) chk(1'b1, req, 0, 0);
        else begin
            $display("FAIL %s: bit stream mismatch at sample %0d", req, bad);
            chk(1'b0, req, int'(cap[bad]), int'(expb[bad]));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R1 reset line", int'(txd), 1);
        chk(ready == 1'b0, "R1 reset ready", int'(ready), 0);
        chk(empty == 1'b1, "R1 reset empty", int'(empty), 1);

        // Vector table walk: R2 R3 R4 R5 R6 R7 R8
        wr(8'h01, 1);
        for (int v = 0; v < NVEC; v++) begin
            wr(VECS[v].fmt, 0);
            wr(VECS[v].data, 2);
            chk(ready == 1'b0, "R7 ready drops after write", int'(ready), 0);
            chk(empty == 1'b0, "R8 empty drops after write", int'(empty), 0);
            ncap = 0;
            nexp = 0;
            add_frame(VECS[v].fmt, VECS[v].data);
            push(1'b1, 4);
            run_ticks(nexp);
            cmp_stream(nexp, "R2 R3 R4 R5 R6 frame");
            chk(empty == 1'b1, "R8 empty after frame", int'(empty), 1);
        end

        // R7 ready conditions
        cts_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b0, "R7 ready with cts inactive", int'(ready), 0);
        cts_n = 1'b0;
        @(negedge clk);
        chk(ready == 1'b1, "R7 ready with cts active", int'(ready), 1);
        wr(8'h00, 1);
        chk(ready == 1'b0, "R7 ready with transmit disabled", int'(ready), 0);
        wr(8'h01, 1);

        // R9 back-to-back frames, no gap
        wr(8'h4D, 0);
        wr(8'h6E, 2);
        ncap = 0;
        nexp = 0;
        add_frame(8'h4D, 8'h6E);
        add_frame(8'h4D, 8'h93);
        push(1'b1, 3);
        run_ticks(1);
        chk(ready == 1'b1, "R9 holding freed at frame start", int'(ready), 1);
        chk(empty == 1'b0, "R8 empty low while shifting", int'(empty), 0);
        wr(8'h93, 2);
        wr(8'h11, 2);
        chk(ready == 1'b0, "R9 holding full during frame", int'(ready), 0);
        run_ticks(nexp - 1);
        cmp_stream(nexp, "R9 back-to-back stream, extra write ignored");

        // R10 clear-to-send withdrawn mid-frame
        wr(8'h27, 2);
        ncap = 0;
        nexp = 0;
        add_frame(8'h4D, 8'h27);
        push(1'b1, 5);
        run_ticks(3);
        cts_n = 1'b1;
        wr(8'hB4, 2);
        run_ticks(nexp - 3);
        cmp_stream(nexp, "R10 frame completes after cts drop");
        chk(empty == 1'b0, "R10 held character pending", int'(empty), 0);
        wr(8'h00, 1);
        cts_n = 1'b0;
        ncap = 0;
        nexp = 0;
        push(1'b1, 4);
        run_ticks(4);
        cmp_stream(4, "R10 no start without transmit enable");
        wr(8'h01, 1);
        ncap = 0;
        nexp = 0;
        add_frame(8'h4D, 8'hB4);
        push(1'b1, 2);
        run_ticks(nexp);
        cmp_stream(nexp, "R10 held frame after re-enable");

        // R11 break
        wr(8'h09, 1);
        chk(txd == 1'b0, "R11 break forces low", int'(txd), 0);
        wr(8'h01, 1);
        chk(txd == 1'b1, "R11 line restored", int'(txd), 1);

        // R12 format captured at frame start
        wr(8'hC3, 2);
        ncap = 0;
        nexp = 0;
        add_frame(8'h4D, 8'hC3);
        push(1'b1, 2);
        run_ticks(2);
        wr(8'hF1, 0);
        run_ticks(nexp - 2);
        cmp_stream(nexp, "R12 format latched per frame");
        chk(stable_bad == 0, "R12 line quiet between ticks", stable_bad, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule